// File: doc/BRIEF.md
# Low-Power Compare Timer

This block is a small register-mapped timer built around a 16-bit up-counter and a compare register. One of four tick sources can drive it. The chosen source is brought into the bus clock domain and reduced to a single-cycle edge pulse. That pulse can go straight to the counter or through a power-of-two prescaler. When the counter sits at the compare value and one more tick arrives, the counter returns to zero and a sticky compare flag is raised. An interrupt line reflects that flag whenever interrupts are enabled.

Software drives the timer through four word registers. The control/status register sits at byte offset 0x0, the prescale/select register at 0x4, the compare register at 0x8 and the count register at 0xC. Three protections keep software and the running counter consistent:

- The live count is never read directly. A full-word write to the count register copies it into a holding register, and reads return that copy.
- While the timer runs, the compare value can only be changed while the flag is set.
- Turning the timer off clears the counter. The first tick after turning it back on only holds the counter at zero, so one tick is consumed by the restart.

Top module: `lp_cmp_timer`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: With the prescaler bypassed, each rising edge of the selected source advances the counter by one. A write to offset 0xC with all four byte enables set copies the counter into the holding register, and reads of 0xC return that copy.
- R3: A write to offset 0xC with any byte enable clear does not capture the counter, so the holding register keeps its previous value.
- R4: When a tick arrives while the counter equals the compare value, the counter goes to zero and the flag (control bit 2) becomes 1. One period therefore spans compare+1 ticks.
- R5: Writing 1 to control bit 2 clears the flag. Writing 0 to that bit leaves the flag unchanged.
- R6: `irq_o` is high exactly when the flag and the interrupt-enable bit (control bit 1) are both 1.
- R7: A write to the compare register (offset 0x8) is accepted while the timer is disabled (control bit 0 = 0) or while the flag is set. It is ignored while the timer is enabled and the flag is clear.
- R8: Clearing control bit 0 forces the counter to zero. After the timer is enabled again, the first tick leaves the counter at zero and the next tick makes it one.
- R9: With prescale bypass (bit 2 of offset 0x4) at 0, the counter advances once every 2^(N+1) source edges, where N is bits 6:3 of offset 0x4.
- R10: Bits 1:0 of offset 0x4 select which of the four sources drives the counter. Edges on the other sources have no effect on the count.
- R11: Writes to offset 0x4 are ignored while the timer is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low reset |
| src_i | input | 4 | Raw tick sources, asynchronous to `clk` |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte enables; only the count capture uses them |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Compare interrupt |

## Verification
The hardest situation to reach from the ports is a compare write that races the running counter. The write must land while the timer is enabled and must be tested once with the flag set and once with it clear. The bench gets there by counting source edges up to the compare value exactly. It lets one more edge raise the flag, rewrites the compare value with the flag set, then clears the flag and tries a second rewrite. Capture reads between edges show both the lost restart tick and the new period length.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_PSR  = 2'd1,
      SEL_CMP  = 2'd2,
      SEL_CNT  = 2'd3
   } reg_sel_e;

   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_IE_BIT   = 1;
   localparam int CTRL_FLAG_BIT = 2;
endpackage

// File: rtl/lpt_tick_sync.sv
module lpt_tick_sync #(
   parameter int NSRC   = 4,
   parameter int STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_i,
   output logic [NSRC-1:0] edge_o
);
   localparam int CHAIN = STAGES + 1;

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      logic [CHAIN-1:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe_q <= '0;
         else        pipe_q <= {pipe_q[CHAIN-2:0], src_i[s]};
      end
      assign edge_o[s] = pipe_q[CHAIN-2] & ~pipe_q[CHAIN-1];

      p_edge_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
         edge_o[s] |=> !edge_o[s]);
   end
endmodule

// File: rtl/lpt_prescaler.sv
module lpt_prescaler #(
   parameter int PRE_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             bypass_i,
   input  logic [PRE_W-1:0] div_n_i,
   input  logic             edge_i,
   output logic             tick_o
);
   localparam int PC_W = 1 << PRE_W;

   logic [PC_W-1:0] pc_q;
   logic [PC_W:0]   lim_w;
   logic            at_lim;

   always_comb begin
      lim_w  = ((PC_W+1)'(1) << (32'(div_n_i) + 32'd1)) - (PC_W+1)'(1);
      at_lim = (pc_q == lim_w[PC_W-1:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    pc_q <= '0;
      else if (!run_i || bypass_i)   pc_q <= '0;
      else if (edge_i)               pc_q <= at_lim ? '0 : pc_q + 1'b1;
   end

   assign tick_o = run_i & edge_i & (bypass_i | at_lim);

   p_pre_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (pc_q == '0));
endmodule

// File: rtl/lpt_counter.sv
module lpt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] cmp_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             match_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b1;
      end else if (!run_i) begin
         cnt_q   <= '0;
         armed_q <= 1'b1;
      end else if (tick_i) begin
         if (armed_q)              armed_q <= 1'b0;
         else if (cnt_q == cmp_i)  cnt_q   <= '0;
         else                      cnt_q   <= cnt_q + 1'b1;
      end
   end

   assign cnt_o   = cnt_q;
   assign match_o = run_i & tick_i & ~armed_q & (cnt_q == cmp_i);

   p_off_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (cnt_o == '0));
   p_first_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && tick_i && armed_q) |=> (cnt_o == '0));
   p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      match_o |=> (cnt_o == '0));
endmodule

// File: rtl/lp_cmp_timer.sv
module lp_cmp_timer #(
   parameter int CNT_W       = 16,
   parameter int NSRC        = 4,
   parameter int PRE_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [3:0]  src_i,
   input  logic        wr_i,
   input  logic [3:0]  addr_i,
   input  logic [31:0] wdata_i,
   input  logic [3:0]  be_i,
   output logic [31:0] rdata_o,
   output logic        irq_o
);
   import lpt_pkg::*;

   localparam int SEL_W  = $clog2(NSRC);
   localparam int BYP_B  = SEL_W;
   localparam int DIV_LO = SEL_W + 1;
   localparam int PSR_W  = SEL_W + 1 + PRE_W;

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W must lie in 2..32");
   end
   if (NSRC != 4) begin : g_bad_src
      $error("NSRC must match the 4-bit source port");
   end
   if (PRE_W < 1 || PRE_W > 5) begin : g_bad_pre
      $error("PRE_W must lie in 1..5");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (PSR_W > 32) begin : g_bad_psr
      $error("prescale register exceeds a word");
   end

   logic             en_q, ie_q, flag_q;
   logic [SEL_W-1:0] src_q;
   logic             byp_q;
   logic [PRE_W-1:0] div_q;
   logic [CNT_W-1:0] cmp_q, cap_q, cnt_w;
   logic [NSRC-1:0]  edges_w;
   logic             edge_sel, tick_w, match_w;
   reg_sel_e         sel_w;
   logic             wr_ctrl, wr_psr, wr_cmp, wr_cnt, cmp_ok;
   logic             unused_bits;

   assign sel_w       = reg_sel_e'(addr_i[3:2]);
   assign wr_ctrl     = wr_i && sel_w == SEL_CTRL;
   assign wr_psr      = wr_i && sel_w == SEL_PSR && !en_q;
   assign cmp_ok      = !en_q || flag_q;
   assign wr_cmp      = wr_i && sel_w == SEL_CMP && cmp_ok;
   assign wr_cnt      = wr_i && sel_w == SEL_CNT && (&be_i);
   assign unused_bits = ^{addr_i[1:0], wdata_i};

   lpt_tick_sync #(.NSRC(NSRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .edge_o(edges_w));

   assign edge_sel = edges_w[src_q];

   lpt_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run_i(en_q), .bypass_i(byp_q),
      .div_n_i(div_q), .edge_i(edge_sel), .tick_o(tick_w));

   lpt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run_i(en_q), .tick_i(tick_w),
      .cmp_i(cmp_q), .cnt_o(cnt_w), .match_o(match_w));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         ie_q   <= 1'b0;
         flag_q <= 1'b0;
         src_q  <= '0;
         byp_q  <= 1'b0;
         div_q  <= '0;
         cmp_q  <= '0;
         cap_q  <= '0;
      end else begin
         if (wr_ctrl) begin
            en_q <= wdata_i[CTRL_EN_BIT];
            ie_q <= wdata_i[CTRL_IE_BIT];
         end
         flag_q <= (flag_q & ~(wr_ctrl & wdata_i[CTRL_FLAG_BIT])) | match_w;
         if (wr_psr) begin
            src_q <= wdata_i[SEL_W-1:0];
            byp_q <= wdata_i[BYP_B];
            div_q <= wdata_i[DIV_LO +: PRE_W];
         end
         if (wr_cmp) cmp_q <= wdata_i[CNT_W-1:0];
         if (wr_cnt) cap_q <= cnt_w;
      end
   end

   always_comb begin
      rdata_o = '0;
      unique case (sel_w)
         SEL_CTRL: begin
            rdata_o[CTRL_EN_BIT]   = en_q;
            rdata_o[CTRL_IE_BIT]   = ie_q;
            rdata_o[CTRL_FLAG_BIT] = flag_q;
         end
         SEL_PSR:  rdata_o[PSR_W-1:0] = {div_q, byp_q, src_q};
         SEL_CMP:  rdata_o[CNT_W-1:0] = cmp_q;
         SEL_CNT:  rdata_o[CNT_W-1:0] = cap_q;
         default:  rdata_o = '0;
      endcase
   end

   assign irq_o = flag_q & ie_q;

   p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      match_w |=> flag_q);
   p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wdata_i[CTRL_FLAG_BIT] && !match_w) |=> !flag_q);
   p_cmp_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !flag_q) |=> $stable(cmp_q));
   p_psr_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> ($stable(div_q) && $stable(byp_q) && $stable(src_q)));
   p_cap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_i && sel_w == SEL_CNT && (&be_i)) |=> $stable(cap_q));
endmodule

// File: tb/sim_lp_cmp_timer.sv
module sim_lp_cmp_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  src = '0;
   logic        wr = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [3:0]  be = '0;
   logic [31:0] rdata;
   logic        irq;
   int          n_run = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   lp_cmp_timer u0 (
      .clk(clk), .rst_n(rst_n), .src_i(src), .wr_i(wr), .addr_i(addr),
      .wdata_i(wdata), .be_i(be), .rdata_o(rdata), .irq_o(irq));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [31:0] d, input logic [3:0] b);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d; be = b;
      @(negedge clk);
      wr = 1'b0; be = '0;
   endtask

   task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic count_now(output logic [31:0] d);
      wr_reg(4'hC, 32'h0, 4'hF);
      rd_reg(4'hC, d);
   endtask

   task automatic pulse(input int idx, input int times);
      for (int k = 0; k < times; k++) begin
         @(negedge clk); src[idx] = 1'b1;
         repeat (3) @(negedge clk);
         src[idx] = 1'b0;
         repeat (4) @(negedge clk);
      end
   endtask

   task automatic t_reset;
      logic [31:0] d;
      for (int a = 0; a < 16; a += 4) begin
         rd_reg(4'(a), d);
         chk("R1 register reset", d, 32'h0);
      end
      chk("R1 irq reset", {31'h0, irq}, 32'h0);
   endtask

   task automatic t_count_capture;
      logic [31:0] d;
      wr_reg(4'h4, 32'h4, 4'hF);
      wr_reg(4'h8, 32'd10, 4'hF);
      wr_reg(4'h0, 32'h1, 4'hF);
      pulse(0, 4);
      count_now(d);
      chk("R2 R8 count after restart", d, 32'd3);
      pulse(0, 2);
      wr_reg(4'hC, 32'h0, 4'h3);
      rd_reg(4'hC, d);
      chk("R3 partial write no capture", d, 32'd3);
      count_now(d);
      chk("R2 full capture", d, 32'd5);
   endtask

   task automatic t_wrap_flag;
      logic [31:0] d;
      pulse(0, 5);
      count_now(d);
      chk("R4 count at compare", d, 32'd10);
      rd_reg(4'h0, d);
      chk("R4 flag clear before wrap", d, 32'h1);
      pulse(0, 1);
      count_now(d);
      chk("R4 wrap to zero", d, 32'd0);
      rd_reg(4'h0, d);
      chk("R4 flag set on wrap", d, 32'h5);
      chk("R6 irq masked", {31'h0, irq}, 32'h0);
      wr_reg(4'h0, 32'h3, 4'hF);
      rd_reg(4'h0, d);
      chk("R5 zero write keeps flag", d, 32'h7);
      chk("R6 irq raised", {31'h0, irq}, 32'h1);
      wr_reg(4'h8, 32'd3, 4'hF);
      rd_reg(4'h8, d);
      chk("R7 compare write with flag", d, 32'd3);
      wr_reg(4'h0, 32'h7, 4'hF);
      rd_reg(4'h0, d);
      chk("R5 w1c clears flag", d, 32'h3);
      chk("R6 irq dropped", {31'h0, irq}, 32'h0);
      wr_reg(4'h8, 32'd7, 4'hF);
      rd_reg(4'h8, d);
      chk("R7 compare write ignored", d, 32'd3);
      pulse(0, 3);
      count_now(d);
      chk("R4 new period count", d, 32'd3);
      pulse(0, 1);
      rd_reg(4'h0, d);
      chk("R4 period cmp+1 flag", d, 32'h7);
   endtask

   task automatic t_psr_lock;
      logic [31:0] d;
      wr_reg(4'h4, 32'h1, 4'hF);
      rd_reg(4'h4, d);
      chk("R11 prescale locked", d, 32'h4);
   endtask

   task automatic t_disable;
      logic [31:0] d;
      pulse(0, 2);
      count_now(d);
      chk("R8 count before disable", d, 32'd2);
      wr_reg(4'h0, 32'h0, 4'hF);
      count_now(d);
      chk("R8 disable clears", d, 32'd0);
      wr_reg(4'h0, 32'h4, 4'hF);
      wr_reg(4'h0, 32'h1, 4'hF);
      pulse(0, 1);
      count_now(d);
      chk("R8 first tick lost", d, 32'd0);
      pulse(0, 1);
      count_now(d);
      chk("R8 second tick counts", d, 32'd1);
   endtask

   task automatic t_select;
      logic [31:0] d;
      wr_reg(4'h0, 32'h0, 4'hF);
      wr_reg(4'h4, 32'h6, 4'hF);
      wr_reg(4'h8, 32'd100, 4'hF);
      rd_reg(4'h8, d);
      chk("R7 compare write while disabled", d, 32'd100);
      wr_reg(4'h0, 32'h1, 4'hF);
      pulse(2, 1);
      pulse(0, 2);
      pulse(3, 1);
      pulse(2, 2);
      count_now(d);
      chk("R10 only selected source", d, 32'd2);
   endtask

   task automatic t_prescale;
      logic [31:0] d;
      wr_reg(4'h0, 32'h0, 4'hF);
      wr_reg(4'h4, 32'h9, 4'hF);
      rd_reg(4'h4, d);
      chk("R9 prescale written", d, 32'h9);
      wr_reg(4'h0, 32'h1, 4'hF);
      pulse(1, 4);
      count_now(d);
      chk("R9 first divided tick lost", d, 32'd0);
      pulse(1, 8);
      count_now(d);
      chk("R9 divide by four", d, 32'd2);
      pulse(1, 3);
      count_now(d);
      chk("R9 partial period", d, 32'd2);
      pulse(1, 1);
      count_now(d);
      chk("R9 period complete", d, 32'd3);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_count_capture();
      t_wrap_flag();
      t_psr_lock();
      t_disable();
      t_select();
      t_prescale();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule